// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is a parallel-in, serial-out shift register with a configurable number of stages, eight by default. It lives in one system clock domain. A device-level shift clock, a clock-blocking input and an active-low load control arrive as plain levels. The block samples them and finds their edges in that domain. A user either captures a whole word from the parallel bus or moves the word one place toward the last stage on each qualified shift edge. The serial input fills the first stage. The last stage is driven out both true and inverted.

The shift clock and the blocking input are symmetric. The effective clock is their combination, so a rising edge on either one counts while the other is low. Holding either one high freezes the register. Load has priority over any shift. Every input, data included, passes through the same two-flop sampling path, so controls and data stay aligned to one another.

Top module: `pload_shreg`

## Requirements
- R1: A synchronous active-low reset clears every stage, so after a reset edge `last_q` is 0 and `last_qn` is 1.
- R2: While the sampled `load_n` is 0, every stage takes its bit of `par_in` on each system clock, whatever `shift_clk`, `clk_block` and `ser_in` do. Bit 0 goes to the first stage and bit STAGES-1 goes to the last stage.
- R3: A shift needs three things: a sampled rising edge of `shift_clk`, a sampled `clk_block` that is 0, and a sampled `load_n` that is 1. On a shift the first stage takes `ser_in` and every other stage takes the value of the stage before it.
- R4: The roles of the two clock inputs swap. A sampled rising edge of `clk_block` while the sampled `shift_clk` is 0 and `load_n` is 1 also causes one shift.
- R5: While either `shift_clk` or `clk_block` is held high, and `load_n` is 1, the register keeps its contents. Edges of the other input and changes on `ser_in` have no effect.
- R6: If the sampled `shift_clk` and `clk_block` rise in the same system cycle, no shift happens.
- R7: `last_qn` is always the inverse of `last_q`.
- R8: An input value present at one system clock edge reaches the stages at the second edge after it. The output therefore shows it after the third edge, counting from the edge that sampled it.
- R9: While `load_n` is 1, changes on `par_in` do not change the stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; all state is updated on its rising edge |
| sys_rst_n | input | 1 | Synchronous reset, active low |
| par_in | input | STAGES | Parallel word; bit 0 goes to the first stage |
| ser_in | input | 1 | Serial bit that enters the first stage on a shift |
| load_n | input | 1 | 0 captures the parallel word, 1 allows shifting |
| shift_clk | input | 1 | Device-level shift clock, edge-detected in the system domain |
| clk_block | input | 1 | Clock-blocking input; it acts as the shift clock when `shift_clk` is low |
| last_q | output | 1 | Value of the last stage |
| last_qn | output | 1 | Inverse of the last stage |

## Verification
Two functions can fall in the same system cycle. A rising edge on `shift_clk` can coincide with a rising edge on `clk_block`, and a shift edge can coincide with a load request. The bench raises both clock inputs on one falling system edge, after loading a word whose last two bits differ, and expects `last_q` to keep its value. It also toggles both clock inputs at random while `load_n` is low and expects the loaded word to win. A behavioural queue model of the register, fed from a history of the sampled inputs, is compared with both outputs on every cycle. This check covers the random inhibit gaps placed between shifts.

// File: rtl/pls_pkg.sv
// Shared types for the parallel-load shift register.
// Assumes: the control inputs are sampled together as one packed vector.
package pls_pkg;

    // Sampled control group; the bit order is fixed by this struct.
    typedef struct packed {
        logic ld_n;
        logic blk;
        logic clk;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Idle control value used during reset: no load, both clocks low.
    localparam ctl_t CTL_IDLE = '{ld_n: 1'b1, blk: 1'b0, clk: 1'b0};

endpackage

// File: rtl/pls_sync2.sv
// Two-flop sampling stage for a group of asynchronous levels.
// Assumes: each bit is sampled on its own; a reset loads RST_VAL into both flops.
module pls_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic          sys_clk,
    input  logic          sys_rst_n,
    input  logic [W-1:0]  d_in,
    output logic [W-1:0]  q_out
);

    logic [W-1:0] meta_q;

    // Shift the input through two flops, resetting both to the idle value.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            meta_q <= RST_VAL;
            q_out  <= RST_VAL;
        end else begin
            meta_q <= d_in;
            q_out  <= meta_q;
        end
    end

endmodule

// File: rtl/pls_edge_qual.sv
// Finds rising edges of the sampled shift clock and blocking input.
// It qualifies them into one shift strobe and passes the load request on.
// Assumes: its inputs are already in the system domain.
// Coincident rises of both inputs yield no strobe.
module pls_edge_qual (
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic s_clk,
    input  logic s_blk,
    input  logic s_ld_n,
    output logic rise_clk,
    output logic rise_blk,
    output logic shift_fire,
    output logic load_now
);

    logic clk_prev;
    logic blk_prev;

    // Keep last cycle's sampled clock levels for edge detection.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            clk_prev <= 1'b0;
            blk_prev <= 1'b0;
        end else begin
            clk_prev <= s_clk;
            blk_prev <= s_blk;
        end
    end

    // An edge counts only while the partner input is low, and never during a load.
    always_comb begin
        rise_clk   = s_clk & ~clk_prev;
        rise_blk   = s_blk & ~blk_prev;
        load_now   = ~s_ld_n;
        shift_fire = s_ld_n & ((rise_clk & ~s_blk) | (rise_blk & ~s_clk));
    end

endmodule

// File: rtl/pls_stage_chain.sv
// The register stages: a level-sensitive parallel load with priority, else a shift.
// Assumes: load and shift come from the same sampled control group.
module pls_stage_chain #(
    parameter int STAGES = 8
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              load_now,
    input  logic              shift_fire,
    input  logic [STAGES-1:0] par_s,
    input  logic              ser_s,
    output logic [STAGES-1:0] stage_q
);

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            logic shift_src;
            if (gi == 0) begin : g_head
                assign shift_src = ser_s;
            end else begin : g_body
                assign shift_src = stage_q[gi-1];
            end

            // One stage: reset, then load, then shift, else hold.
            always_ff @(posedge sys_clk) begin
                if (!sys_rst_n)
                    stage_q[gi] <= 1'b0;
                else if (load_now)
                    stage_q[gi] <= par_s[gi];
                else if (shift_fire)
                    stage_q[gi] <= shift_src;
            end
        end
    endgenerate

endmodule

// File: rtl/pload_shreg.sv
// Top of the parallel-load shift register.
// It samples every input through two flops, qualifies the shift edges,
// and drives the last stage out true and inverted.
// Assumes: one system clock; the device-level clock is much slower than it.
module pload_shreg #(
    parameter int STAGES = 8
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic [STAGES-1:0] par_in,
    input  logic              ser_in,
    input  logic              load_n,
    input  logic              shift_clk,
    input  logic              clk_block,
    output logic              last_q,
    output logic              last_qn
);
    import pls_pkg::*;

    localparam int DAT_W = STAGES + 1;

    ctl_t              ctl_raw;
    ctl_t              ctl_s;
    logic [DAT_W-1:0]  dat_s;
    logic [STAGES-1:0] par_s;
    logic              ser_s;
    logic              s_clk;
    logic              s_blk;
    logic              s_ld_n;
    logic              rise_clk;
    logic              rise_blk;
    logic              shift_fire;
    logic              load_now;
    logic [STAGES-1:0] stage_q;

    assign ctl_raw = '{ld_n: load_n, blk: clk_block, clk: shift_clk};

    pls_sync2 #(.W(CTL_W), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .sys_clk  (sys_clk),
        .sys_rst_n(sys_rst_n),
        .d_in     (ctl_raw),
        .q_out    (ctl_s)
    );

    pls_sync2 #(.W(DAT_W), .RST_VAL('0)) u_dat_sync (
        .sys_clk  (sys_clk),
        .sys_rst_n(sys_rst_n),
        .d_in     ({ser_in, par_in}),
        .q_out    (dat_s)
    );

    // Split the sampled groups back into named fields.
    always_comb begin
        s_clk  = ctl_s.clk;
        s_blk  = ctl_s.blk;
        s_ld_n = ctl_s.ld_n;
        par_s  = dat_s[STAGES-1:0];
        ser_s  = dat_s[STAGES];
    end

    pls_edge_qual u_qual (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .s_clk     (s_clk),
        .s_blk     (s_blk),
        .s_ld_n    (s_ld_n),
        .rise_clk  (rise_clk),
        .rise_blk  (rise_blk),
        .shift_fire(shift_fire),
        .load_now  (load_now)
    );

    pls_stage_chain #(.STAGES(STAGES)) u_chain (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .load_now  (load_now),
        .shift_fire(shift_fire),
        .par_s     (par_s),
        .ser_s     (ser_s),
        .stage_q   (stage_q)
    );

    // Drive the last stage out in both polarities.
    always_comb begin
        last_q  = stage_q[STAGES-1];
        last_qn = ~stage_q[STAGES-1];
    end

endmodule

// File: rtl/pls_checker.sv
// Property checker for pload_shreg, bound into every instance of it.
// Assumes: it is connected to the top's sampled controls and stage vector.
module pls_checker #(
    parameter int STAGES = 8
) (
    input logic              sys_clk,
    input logic              sys_rst_n,
    input logic [STAGES-1:0] stage_q,
    input logic [STAGES-1:0] par_s,
    input logic              ser_s,
    input logic              s_clk,
    input logic              s_blk,
    input logic              rise_clk,
    input logic              rise_blk,
    input logic              shift_fire,
    input logic              load_now,
    input logic              last_q,
    input logic              last_qn
);

    // R1
    reset_clear_chk: assert property (@(posedge sys_clk)
        !sys_rst_n |=> (stage_q == '0));

    // R2
    load_take_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        load_now |=> (stage_q == $past(par_s)));

    // R3
    shift_move_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (shift_fire && !load_now) |=>
            (stage_q == {$past(stage_q[STAGES-2:0]), $past(ser_s)}));

    // R4
    blk_as_clk_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (rise_blk && !s_clk && !load_now) |-> shift_fire);

    // R5
    hold_state_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (!load_now && !shift_fire) |=> $stable(stage_q));

    // R6
    dual_rise_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (rise_clk && rise_blk) |-> !shift_fire);

    // R5
    held_high_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        ($past(s_clk) && $past(s_blk)) |-> !shift_fire);

    // R7
    compl_out_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        1'b1 |=> (last_qn != last_q));

endmodule

bind pload_shreg pls_checker #(.STAGES(STAGES)) u_pls_chk (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .stage_q   (stage_q),
    .par_s     (par_s),
    .ser_s     (ser_s),
    .s_clk     (s_clk),
    .s_blk     (s_blk),
    .rise_clk  (rise_clk),
    .rise_blk  (rise_blk),
    .shift_fire(shift_fire),
    .load_now  (load_now),
    .last_q    (last_q),
    .last_qn   (last_qn)
);

// File: tb/pload_shreg_tb_top.sv
// Bench for pload_shreg: a behavioural queue model driven from a history of
// the inputs, compared with the outputs on every falling system edge,
// plus directed checks.
module pload_shreg_tb_top;
    localparam int N = 8;

    typedef struct {
        logic         c;
        logic         b;
        logic         l;
        logic [N-1:0] p;
        logic         s;
    } in_rec_t;

    logic         sys_clk = 1'b0;
    logic         sys_rst_n = 1'b0;
    logic [N-1:0] par_in = '0;
    logic         ser_in = 1'b0;
    logic         load_n = 1'b1;
    logic         shift_clk = 1'b0;
    logic         clk_block = 1'b0;
    logic         last_q;
    logic         last_qn;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    logic    mdl[$];
    in_rec_t hist[$];
    logic    ref_q[$];

    pload_shreg #(.STAGES(N)) dut_i (
        .sys_clk  (sys_clk),
        .sys_rst_n(sys_rst_n),
        .par_in   (par_in),
        .ser_in   (ser_in),
        .load_n   (load_n),
        .shift_clk(shift_clk),
        .clk_block(clk_block),
        .last_q   (last_q),
        .last_qn  (last_qn)
    );

    always #2 sys_clk = ~sys_clk;

    function automatic in_rec_t idle_rec();
        in_rec_t r;
        r.c = 1'b0; r.b = 1'b0; r.l = 1'b1; r.p = '0; r.s = 1'b0;
        return r;
    endfunction

    // Reference model: an input takes effect two edges after it is sampled.
    always @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            mdl.delete();
            for (int i = 0; i < N; i++) mdl.push_back(1'b0);
            hist.delete();
            for (int i = 0; i < 3; i++) hist.push_back(idle_rec());
        end else begin
            in_rec_t cur;
            in_rec_t prv;
            in_rec_t now_r;
            cur = hist[hist.size()-2];
            prv = hist[hist.size()-3];
            if (!cur.l) begin
                for (int i = 0; i < N; i++) mdl[i] = cur.p[i];
            end else if ((cur.c && !prv.c && !cur.b) || (cur.b && !prv.b && !cur.c)) begin
                mdl.push_front(cur.s);
                void'(mdl.pop_back());
            end
            now_r.c = shift_clk; now_r.b = clk_block; now_r.l = load_n;
            now_r.p = par_in;    now_r.s = ser_in;
            hist.push_back(now_r);
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    // Per-cycle comparison against the model (R7 is checked here too).
    always @(negedge sys_clk) begin
        if (!done && mdl.size() == N) begin
            n_cmp++;
            if (last_q !== mdl[N-1]) begin
                n_bad++;
                $display("FAIL %s model compare: last_q=%b expected %b at %0t", cur_req, last_q, mdl[N-1], $time);
            end
            n_cmp++;
            if (last_qn !== ~mdl[N-1]) begin
                n_bad++;
                $display("FAIL R7 complement: last_qn=%b expected %b at %0t", last_qn, ~mdl[N-1], $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic load_word(input logic [N-1:0] w);
        shift_clk = 1'b0; clk_block = 1'b0; par_in = w; load_n = 1'b0;
        tick(4);
        load_n = 1'b1;
        tick(4);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 60000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [N-1:0] w;
        logic hold_v;

        // R1: reset state
        cur_req = "R1";
        tick(4);
        check("R1 reset q", last_q, 1'b0);
        check("R1 reset qn", last_qn, 1'b1);
        sys_rst_n = 1'b1;
        tick(3);

        // R2: load while clocks and serial input toggle at random
        cur_req = "R2";
        w = N'($urandom);
        w[N-1] = 1'b1;
        par_in = w; load_n = 1'b0;
        for (int i = 0; i < 12; i++) begin
            shift_clk = 1'($urandom); clk_block = 1'($urandom); ser_in = 1'($urandom);
            tick(1);
        end
        check("R2 load under clock noise", last_q, w[N-1]);
        w[N-1] = 1'b0; par_in = w;
        tick(3);
        check("R2 level load follows bus", last_q, 1'b0);
        shift_clk = 1'b0; clk_block = 1'b0;
        tick(3);
        load_n = 1'b1;
        tick(4);

        // R9: bus changes ignored with load high
        cur_req = "R9";
        hold_v = last_q;
        for (int i = 0; i < 6; i++) begin
            par_in = N'($urandom);
            tick(1);
        end
        tick(3);
        check("R9 bus ignored", last_q, hold_v);

        // R8: latency of a load request
        cur_req = "R8";
        hold_v = last_q;
        par_in = '0; par_in[N-1] = ~hold_v; load_n = 1'b0;
        tick(1);
        check("R8 after 1 edge", last_q, hold_v);
        tick(1);
        check("R8 after 2 edges", last_q, hold_v);
        tick(1);
        check("R8 after 3 edges", last_q, ~hold_v);
        load_n = 1'b1;
        tick(4);

        // R3/R5: shift out random words with random inhibit gaps
        for (int rep = 0; rep < 6; rep++) begin
            cur_req = "R3";
            w = N'($urandom);
            load_word(w);
            ref_q.delete();
            for (int i = N-1; i >= 0; i--) ref_q.push_back(w[i]);
            for (int k = 0; k < 2*N; k++) begin
                logic sb;
                sb = 1'($urandom);
                ref_q.push_back(sb);
                check("R3 serial order", last_q, ref_q[k]);
                ser_in = sb;
                shift_clk = 1'b1;
                tick(3);
                ser_in = 1'($urandom);
                if ($urandom % 2 == 1) begin
                    cur_req = "R5";
                    hold_v = last_q;
                    clk_block = 1'b1;
                    tick(1 + $urandom % 4);
                    shift_clk = 1'b0;
                    tick(1 + $urandom % 4);
                    shift_clk = 1'b1;
                    tick(1 + $urandom % 4);
                    clk_block = 1'b0;
                    tick(3);
                    check("R5 inhibit gap holds", last_q, hold_v);
                    cur_req = "R3";
                end
                shift_clk = 1'b0;
                tick(2);
            end
        end

        // R5: clock held high while blocking input toggles freely
        cur_req = "R5";
        load_word(N'($urandom));
        shift_clk = 1'b1;
        tick(4);
        hold_v = last_q;
        for (int i = 0; i < 10; i++) begin
            clk_block = 1'($urandom); ser_in = 1'($urandom);
            tick(2);
        end
        clk_block = 1'b0;
        tick(3);
        check("R5 clock held high", last_q, hold_v);
        shift_clk = 1'b0;
        tick(3);

        // R4: blocking input acts as the clock
        cur_req = "R4";
        w = '0; w[N-1] = 1'b1; w[N-2] = 1'b0;
        load_word(w);
        check("R4 before edge", last_q, 1'b1);
        clk_block = 1'b1;
        tick(3);
        check("R4 shift on inhibit edge", last_q, 1'b0);
        clk_block = 1'b0;
        tick(3);

        // R6: both inputs rise together
        cur_req = "R6";
        load_word(w);
        shift_clk = 1'b1; clk_block = 1'b1;
        tick(4);
        check("R6 dual rise no shift", last_q, 1'b1);
        clk_block = 1'b0;
        tick(2);
        shift_clk = 1'b0;
        tick(3);
        check("R6 falls no shift", last_q, 1'b1);

        // R1: reset in the middle of operation
        cur_req = "R1";
        load_word(N'(1) << (N-1));
        sys_rst_n = 1'b0;
        tick(2);
        check("R1 mid reset q", last_q, 1'b0);
        check("R1 mid reset qn", last_qn, 1'b1);
        sys_rst_n = 1'b1;
        tick(4);

        finish_run();
    end

endmodule